// File: doc/BRIEF.md
# Nonvolatile State Save/Restore Sequencer

This block is the clocked controller that sits between an energy harvester and a datapath whose flip-flops keep their contents in ferroelectric storage. An asynchronous energy-good level is brought into the controller clock domain. The block then drives the controls that move the slave-latch state into and out of storage. These controls are an isolation gate, a capacitor lock, a node-clear strobe and the nonvolatile rail enable. The block also drives a clock enable that freezes the datapath, and a flag saying that supply power may be removed.

When energy goes away, the datapath is frozen first. After that the save steps run on a fixed schedule, and the block reports that power can be cut. When energy comes back, the steps are undone in mirror order. The restored data is valid early in the restore, and the datapath clock is released at the end of the restore. A change of the energy level in the middle of a sequence never cuts that sequence short. The opposite sequence simply follows it.

Every control output is a registered, active-high level. The cycle budgets are parameters. The defaults are a two-stage synchronizer, three cycles from lock to clear, two discharge cycles and four settle cycles.

Top module: `nvs_ctrl`

## Requirements
- R1: While reset is low, and after it, the block sits in the saved state: dp_clk_en=0, iso_gate=1, cap_lock=1, node_clear=1, nv_rail_en=0, power_cut_ok=1.
- R2: energy_good_a passes through a two-stage synchronizer. Take the first rising clock edge that samples a new level as edge 1. No output changes at edges 1 and 2.
- R3: On a fall of energy_good_a seen in the active state, dp_clk_en goes to 0 at edge 3. At that edge every other control is unchanged, and no save control moves before the freeze.
- R4: iso_gate rises at edge 4, and cap_lock rises at edge 5.
- R5: node_clear rises at edge 8, which completes the save.
- R6: nv_rail_en falls at edge 9. power_cut_ok rises at edge 10, two edges after node_clear.
- R7: On a rise of energy_good_a seen in the saved state, the restore runs as follows. node_clear and power_cut_ok fall at edge 3. nv_rail_en rises at edge 4, iso_gate falls at edge 5 and cap_lock falls at edge 6.
- R8: dp_clk_en rises at edge 10 of the restore. From then on the outputs are dp_clk_en=1, nv_rail_en=1 and all others 0.
- R9: If energy returns in the middle of a save, the save still runs to its end. The restore then starts at the next edge, which counts as restore edge 3.
- R10: If energy falls in the middle of a restore, the restore still runs to its end. The save then starts at the next edge, which counts as save edge 3.
- R11: While energy_good_a stays high in the active state, no output changes. While it stays low in the saved state, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, free running |
| rst_n | input | 1 | Asynchronous active-low reset |
| energy_good_a | input | 1 | Asynchronous energy-available level from the harvester |
| dp_clk_en | output | 1 | Datapath clock enable (0 holds the clock low) |
| iso_gate | output | 1 | Cuts the storage nodes off the latch supply |
| cap_lock | output | 1 | Preserves the already-written storage capacitor |
| node_clear | output | 1 | Equalizes the floating latch nodes |
| nv_rail_en | output | 1 | Enables the nonvolatile supply rail |
| power_cut_ok | output | 1 | Supply may be removed |

## Verification
Five stimulus patterns are applied to the controls:
- **Clean power-up after reset.** This checks the restore schedule with no history behind it.
- **Clean fall and clean rise.** These are compared against the exact edge of every control. A one-edge shift in the synchronizer depth or in any step count shows up.
- **Rise during a save and fall during a restore.** These tell a controller that completes each sequence apart from one that aborts it or skips a step.
- **Long steady stretches.** These are held in both the active and the saved state to show that nothing moves without an input change.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
   typedef enum logic [1:0] {
      ST_ACTIVE  = 2'd0,
      ST_SAVE    = 2'd1,
      ST_OFF     = 2'd2,
      ST_RESTORE = 2'd3
   } nvs_state_e;

   typedef struct packed {
      logic clk_en;
      logic gate;
      logic lock;
      logic clear;
      logic rail;
      logic cut;
   } nvs_ctl_t;

   localparam nvs_ctl_t CTL_SAVED = '{clk_en: 1'b0, gate: 1'b1, lock: 1'b1,
                                      clear: 1'b1, rail: 1'b0, cut: 1'b1};
endpackage

// File: rtl/nvs_sync.sv
module nvs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_a,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("nvs_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d_a;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/nvs_fsm.sv
module nvs_fsm
   import nvs_pkg::*;
#(
   parameter int LOCK_TO_CLEAR = 3,
   parameter int DISCHARGE_CYC = 2,
   parameter int SETTLE_CYC    = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ok_s,
   output nvs_ctl_t ctl
);
   localparam int CLEAR_AT   = 1 + LOCK_TO_CLEAR;
   localparam int RAIL_AT    = CLEAR_AT + 1;
   localparam int CUT_AT     = CLEAR_AT + DISCHARGE_CYC;
   localparam int RELEASE_AT = 2 + SETTLE_CYC;
   localparam int LAST       = (CUT_AT > RELEASE_AT) ? CUT_AT : RELEASE_AT;
   localparam int CNT_W      = $clog2(LAST + 2);

   generate
      if (LOCK_TO_CLEAR < 1) begin : g_bad_lock
         $error("nvs_fsm: LOCK_TO_CLEAR must be at least 1");
      end
      if (DISCHARGE_CYC < 2) begin : g_bad_dis
         $error("nvs_fsm: DISCHARGE_CYC must be at least 2");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("nvs_fsm: SETTLE_CYC must be at least 1");
      end
   endgenerate

   nvs_state_e       st;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_OFF;
         cnt <= '0;
         ctl <= CTL_SAVED;
      end else begin
         case (st)
            ST_ACTIVE: begin
               if (!ok_s) begin
                  st         <= ST_SAVE;
                  cnt        <= '0;
                  ctl.clk_en <= 1'b0;
               end
            end
            ST_SAVE: begin
               cnt <= cnt + 1'b1;
               if (cnt == '0)                    ctl.gate  <= 1'b1;
               if (cnt == CNT_W'(1))             ctl.lock  <= 1'b1;
               if (cnt == CNT_W'(CLEAR_AT))      ctl.clear <= 1'b1;
               if (cnt == CNT_W'(RAIL_AT))       ctl.rail  <= 1'b0;
               if (cnt == CNT_W'(CUT_AT)) begin
                  ctl.cut <= 1'b1;
                  st      <= ST_OFF;
               end
            end
            ST_OFF: begin
               if (ok_s) begin
                  st        <= ST_RESTORE;
                  cnt       <= '0;
                  ctl.clear <= 1'b0;
                  ctl.cut   <= 1'b0;
               end
            end
            ST_RESTORE: begin
               cnt <= cnt + 1'b1;
               if (cnt == '0)          ctl.rail <= 1'b1;
               if (cnt == CNT_W'(1))   ctl.gate <= 1'b0;
               if (cnt == CNT_W'(2))   ctl.lock <= 1'b0;
               if (cnt == CNT_W'(RELEASE_AT)) begin
                  ctl.clk_en <= 1'b1;
                  st         <= ST_ACTIVE;
               end
            end
            default: st <= ST_OFF;
         endcase
      end
   end

   // lock may only rise while the gate has already been closed for a cycle
   p_lock_after_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl.lock) |-> (ctl.gate && $past(ctl.gate)));

   // rail only drops once the latch nodes are cleared
   p_rail_after_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl.rail) |-> ctl.clear);

   // gate opens only after the rail was back for a cycle
   p_gate_after_rail_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl.gate) |-> (ctl.rail && $past(ctl.rail)));
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
   import nvs_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int LOCK_TO_CLEAR = 3,
   parameter int DISCHARGE_CYC = 2,
   parameter int SETTLE_CYC    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic energy_good_a,
   output logic dp_clk_en,
   output logic iso_gate,
   output logic cap_lock,
   output logic node_clear,
   output logic nv_rail_en,
   output logic power_cut_ok
);
   logic     ok_s;
   nvs_ctl_t ctl;

   nvs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_a   (energy_good_a),
      .q     (ok_s)
   );

   nvs_fsm #(
      .LOCK_TO_CLEAR (LOCK_TO_CLEAR),
      .DISCHARGE_CYC (DISCHARGE_CYC),
      .SETTLE_CYC    (SETTLE_CYC)
   ) u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .ok_s  (ok_s),
      .ctl   (ctl)
   );

   assign dp_clk_en    = ctl.clk_en;
   assign iso_gate     = ctl.gate;
   assign cap_lock     = ctl.lock;
   assign node_clear   = ctl.clear;
   assign nv_rail_en   = ctl.rail;
   assign power_cut_ok = ctl.cut;

   // datapath already frozen when the gate closes
   p_freeze_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iso_gate) |-> !dp_clk_en);

   // cut flag only with rail off and nodes cleared
   p_cut_safe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      power_cut_ok |-> (!nv_rail_en && node_clear && cap_lock && iso_gate));

   // running datapath sees fully released controls
   p_run_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dp_clk_en |-> (!iso_gate && !cap_lock && !node_clear && nv_rail_en && !power_cut_ok));
endmodule

// File: tb/sim_nvs_ctrl.sv
`timescale 1ns/1ps
module sim_nvs_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic energy_good_a = 1'b1;
   logic dp_clk_en, iso_gate, cap_lock, node_clear, nv_rail_en, power_cut_ok;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 1'b0;

   typedef struct {
      int         at;
      logic [5:0] v;
      string      tag;
   } item_t;
   item_t q[$];

   localparam logic [5:0] V_OFF = 6'b011101;
   localparam logic [5:0] V_RUN = 6'b100010;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   nvs_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .energy_good_a(energy_good_a),
      .dp_clk_en(dp_clk_en), .iso_gate(iso_gate), .cap_lock(cap_lock),
      .node_clear(node_clear), .nv_rail_en(nv_rail_en), .power_cut_ok(power_cut_ok)
   );

   wire [5:0] outs = {dp_clk_en, iso_gate, cap_lock, node_clear, nv_rail_en, power_cut_ok};

   // order: clk_en, gate, lock, clear, rail, cut
   function automatic logic [5:0] vec_save(int k);
      if (k <= 2) return V_RUN;
      case (k)
         3: return 6'b000010;
         4: return 6'b010010;
         5, 6, 7: return 6'b011010;
         8: return 6'b011110;
         9: return 6'b011100;
         default: return V_OFF;
      endcase
   endfunction

   function automatic string tag_save(int k);
      if (k <= 2) return "R2";
      if (k == 3) return "R3";
      if (k <= 5) return "R4";
      if (k <= 8) return "R5";
      return "R6";
   endfunction

   function automatic logic [5:0] vec_rest(int k);
      if (k <= 2) return V_OFF;
      case (k)
         3: return 6'b011000;
         4: return 6'b011010;
         5: return 6'b001010;
         6, 7, 8, 9: return 6'b000010;
         default: return V_RUN;
      endcase
   endfunction

   function automatic string tag_rest(int k);
      if (k <= 2) return "R2";
      if (k <= 6) return "R7";
      return "R8";
   endfunction

   task automatic push(int at, logic [5:0] v, string tag);
      item_t it;
      it.at = at; it.v = v; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic drain();
      while (q.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic hold(int n, logic [5:0] v, string tag);
      int base;
      base = cyc;
      for (int k = 1; k <= n; k++) push(base + k, v, tag);
      drain();
   endtask

   task automatic do_save();
      int base;
      energy_good_a = 1'b0;
      base = cyc;
      for (int k = 1; k <= 10; k++) push(base + k, vec_save(k), tag_save(k));
      drain();
   endtask

   task automatic do_restore();
      int base;
      energy_good_a = 1'b1;
      base = cyc;
      for (int k = 1; k <= 10; k++) push(base + k, vec_rest(k), tag_rest(k));
      drain();
   endtask

   // monitor: compares scoreboard items at the falling edge
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].at == cyc) begin
         item_t it;
         it = q.pop_front();
         checks++;
         if (outs !== it.v) begin
            failures++;
            $display("FAIL %s cycle %0d actual=%b expected=%b", it.tag, cyc, outs, it.v);
         end
      end
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      checks++;
      if (outs !== V_OFF) begin
         failures++;
         $display("FAIL R1 in reset actual=%b expected=%b", outs, V_OFF);
      end
      // release reset with energy present: clean power-up restore
      rst_n = 1'b1;
      base = cyc;
      push(base + 1, V_OFF, "R1");
      for (int k = 2; k <= 10; k++) push(base + k, vec_rest(k), tag_rest(k));
      drain();
      hold(20, V_RUN, "R11");
      do_save();
      hold(15, V_OFF, "R11");
      do_restore();
      hold(5, V_RUN, "R11");
      // R9: energy returns after save edge 5
      energy_good_a = 1'b0;
      base = cyc;
      for (int k = 1; k <= 10; k++) push(base + k, vec_save(k), "R9");
      for (int k = 3; k <= 10; k++) push(base + 8 + k, vec_rest(k), "R9");
      repeat (5) @(negedge clk);
      energy_good_a = 1'b1;
      drain();
      hold(4, V_RUN, "R9");
      // R10: energy drops after restore edge 4
      do_save();
      energy_good_a = 1'b1;
      base = cyc;
      for (int k = 1; k <= 10; k++) push(base + k, vec_rest(k), "R10");
      for (int k = 3; k <= 10; k++) push(base + 8 + k, vec_save(k), "R10");
      repeat (4) @(negedge clk);
      energy_good_a = 1'b0;
      drain();
      hold(6, V_OFF, "R10");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired at cycle %0d actual=timeout expected=completion", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule